// File: doc/BRIEF.md
# Dual Card Channel Switch

This block lets one host serve two card sockets through a single data line, one reset line and one clock line. A select input decides which socket is in session. The host data line is joined only to that socket. The other socket's I/O is released, and that socket keeps its last reset level. A per-channel run input can keep a clock going to an idle socket. Each socket also has a voltage-select bit, which is passed on as a registered level output for the supply regulator.

Every bidirectional line is modelled as an open-drain pair: a drive-low enable from the block and a sampled level from the wire. On the active data path, the first side to pull low owns the path until it lets go. This stops the block's own drive from being taken for a new low coming from the far side. The block works on a fast system clock. The host card clock is a sampled input whose edges are forwarded, and clock gating changes only while the host clock is low.

A socket whose enable is low is kept quiet. Its I/O is pulled low and its reset and clock are held low, whatever the select and run inputs are.

Top module: `card_switch`

## Requirements
- R1: A select value of 0 picks channel A (index 0) and a value of 1 picks channel B (index 1) for the data, reset and clock paths.
- R2: One cycle after any combination of select and voltage bits, `card_vlvl[i]` equals `vsel[i]`, where 1 means the 3V level and 0 means the 1.8V level.
- R3: On the selected, enabled channel, a host low on the data line asserts that card's `card_io_oe` one cycle later, and host release clears it one cycle later.
- R4: On the selected, enabled channel, a card low asserts `host_dat_oe` one cycle later, and card release clears it one cycle later. The host's own drive is never echoed back.
- R5: An enabled but deselected channel has `card_io_oe` low, and a low on its card I/O never reaches `host_dat_oe`.
- R6: While the selected channel is disabled, including when neither channel is enabled, `host_dat_oe` stays low and the host line reads high.
- R7: The selected channel's `card_rst` equals `host_rst` one cycle later.
- R8: A deselected channel's `card_rst` holds the value it had when it was deselected.
- R9: An enabled channel whose run input is high gets the host clock, one cycle later, whether or not it is selected.
- R10: A deselected channel with its run input low has `card_clk` low within two host clock periods, and it stays low.
- R11: Clock gating changes only while `host_clk` is low. A pulse that is in progress when the select changes completes in full, and no partial pulse starts.
- R12: A channel whose enable is low has `card_io_oe` high and `card_rst` and `card_clk` low, starting one cycle after the enable falls. After reset, `card_io_oe` is all ones and every other output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | SEL_W | Selected channel index |
| en | input | N_CH | Per-channel enable |
| vsel | input | N_CH | Per-channel voltage select (1 = 3V, 0 = 1.8V) |
| run | input | N_CH | Per-channel clock-run request |
| host_rst | input | 1 | Host reset level |
| host_clk | input | 1 | Host card clock, sampled |
| host_dat_i | input | 1 | Sampled level of host data line |
| host_dat_oe | output | 1 | Pull host data line low |
| card_io_i | input | N_CH | Sampled level of each card I/O |
| card_io_oe | output | N_CH | Pull each card I/O low |
| card_rst | output | N_CH | Card reset level |
| card_clk | output | N_CH | Card clock |
| card_vlvl | output | N_CH | Registered voltage level per channel |

## Verification
Every output is registered, so each result appears one system cycle after the input that causes it. The exceptions are a change of select or enable: the data path then spends one cycle idle before it follows the new channel, and clock gating waits for the next low phase of `host_clk`. The bench changes inputs just after a falling system edge and samples just after the next one. It waits two cycles after any select or enable change before probing the data path, and it checks card clocks every system cycle through whole host clock phases. The open-drain wires are rebuilt in the bench from the block's enables and the bench's own drivers, so ownership hand-offs are seen exactly as a wire would show them.

// File: rtl/cardsw_pkg.sv
package cardsw_pkg;
    // Which side currently holds the shared data path low.
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_HOST = 2'd1,
        OWN_CARD = 2'd2
    } owner_e;
endpackage

// File: rtl/cardsw_datapath.sv
module cardsw_datapath
    import cardsw_pkg::*;
#(
    parameter int N_CH  = 2,
    parameter int SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [N_CH-1:0]  en,
    input  logic             host_dat_i,
    input  logic [N_CH-1:0]  card_io_i,
    output logic             host_dat_oe,
    output logic [N_CH-1:0]  card_io_oe
);
    typedef struct packed {
        owner_e           own;
        logic [SEL_W-1:0] ch;
        logic [N_CH-1:0]  en;
        logic             host_oe;
        logic [N_CH-1:0]  card_oe;
    } dp_state_t;

    dp_state_t s_d, s_q;
    logic      sel_ok;
    logic      path_ok;
    logic      card_low;

    always_comb begin
        s_d      = s_q;
        sel_ok   = int'(sel) < N_CH;
        // the path is live only once select and enable have been stable for a cycle
        path_ok  = sel_ok && en[sel] && s_q.en[sel] && (sel == s_q.ch);
        card_low = sel_ok ? !card_io_i[sel] : 1'b0;

        if (!path_ok) begin
            s_d.own = OWN_NONE;
        end else begin
            case (s_q.own)
                OWN_NONE: begin
                    if (!host_dat_i)   s_d.own = OWN_HOST;
                    else if (card_low) s_d.own = OWN_CARD;
                end
                OWN_HOST: if (host_dat_i) s_d.own = OWN_NONE;
                OWN_CARD: if (!card_low)  s_d.own = OWN_NONE;
                default:  s_d.own = OWN_NONE;
            endcase
        end

        s_d.ch      = sel;
        s_d.en      = en;
        s_d.host_oe = (s_d.own == OWN_CARD);
        for (int i = 0; i < N_CH; i++) begin
            s_d.card_oe[i] = !en[i] || ((int'(sel) == i) && (s_d.own == OWN_HOST));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.own     <= OWN_NONE;
            s_q.ch      <= '0;
            s_q.en      <= '0;
            s_q.host_oe <= 1'b0;
            s_q.card_oe <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign host_dat_oe = s_q.host_oe;
    assign card_io_oe  = s_q.card_oe;

    // R6: no enabled channel, nothing reaches the host line
    a_r6_host_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(|en) |=> !host_dat_oe);

    // R4: host drive and card-to-host drive never overlap on the selected card
    a_r4_one_way: assert property (@(posedge clk) disable iff (!rst_n)
        host_dat_oe |-> !(|(card_io_oe & s_q.en)));

    for (genvar g = 0; g < N_CH; g++) begin : g_rel
        // R5: deselected enabled channel is released
        a_r5_released: assert property (@(posedge clk) disable iff (!rst_n)
            (en[g] && (int'(sel) != g)) |=> !card_io_oe[g]);
    end
endmodule

// File: rtl/cardsw_lane.sv
module cardsw_lane #(
    parameter int SEL_W = 1,
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             en,
    input  logic             run,
    input  logic             vsel,
    input  logic             host_rst,
    input  logic             host_clk,
    output logic             card_rst,
    output logic             card_clk,
    output logic             card_vlvl
);
    typedef struct packed {
        logic gate;
        logic rst;
        logic ck;
        logic vlvl;
    } lane_state_t;

    lane_state_t s_d, s_q;
    logic        picked;

    always_comb begin
        s_d    = s_q;
        picked = (int'(sel) == IDX);
        // gate may only move during the low phase of the host clock
        if (!host_clk) s_d.gate = en && (picked || run);
        s_d.ck   = host_clk && s_d.gate && en;
        if (!en)         s_d.rst = 1'b0;
        else if (picked) s_d.rst = host_rst;
        s_d.vlvl = vsel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign card_rst  = s_q.rst;
    assign card_clk  = s_q.ck;
    assign card_vlvl = s_q.vlvl;

    // R12: disabled lane is quiet one cycle later
    a_r12_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!card_clk && !card_rst));

    // R8: deselected lane keeps its reset level
    a_r8_rst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (int'(sel) != IDX)) |=> (card_rst == $past(card_rst)));

    // R11: card clock high only behind a high host clock
    a_r11_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
        card_clk |-> $past(host_clk));

    // R2: level output follows its select bit
    a_r2_level: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (card_vlvl == $past(vsel)));
endmodule

// File: rtl/card_switch.sv
module card_switch
    import cardsw_pkg::*;
#(
    parameter int N_CH  = 2,
    parameter int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [N_CH-1:0]  en,
    input  logic [N_CH-1:0]  vsel,
    input  logic [N_CH-1:0]  run,
    input  logic             host_rst,
    input  logic             host_clk,
    input  logic             host_dat_i,
    output logic             host_dat_oe,
    input  logic [N_CH-1:0]  card_io_i,
    output logic [N_CH-1:0]  card_io_oe,
    output logic [N_CH-1:0]  card_rst,
    output logic [N_CH-1:0]  card_clk,
    output logic [N_CH-1:0]  card_vlvl
);
    cardsw_datapath #(.N_CH(N_CH), .SEL_W(SEL_W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .en          (en),
        .host_dat_i  (host_dat_i),
        .card_io_i   (card_io_i),
        .host_dat_oe (host_dat_oe),
        .card_io_oe  (card_io_oe)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_lane
        cardsw_lane #(.SEL_W(SEL_W), .IDX(g)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (sel),
            .en        (en[g]),
            .run       (run[g]),
            .vsel      (vsel[g]),
            .host_rst  (host_rst),
            .host_clk  (host_clk),
            .card_rst  (card_rst[g]),
            .card_clk  (card_clk[g]),
            .card_vlvl (card_vlvl[g])
        );
    end
endmodule

// File: tb/test_card_switch.sv
module test_card_switch;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0;
    logic [1:0] en = '0, vsel = '0, run = '0;
    logic       host_rst = 1'b0, host_clk = 1'b0;
    logic       host_drv = 1'b0;
    logic [1:0] card_drv = '0;
    logic       host_dat_i, host_dat_oe;
    logic [1:0] card_io_i, card_io_oe, card_rst, card_clk, card_vlvl;
    int         checks = 0;
    int         errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // open-drain wires rebuilt from both drivers
    assign host_dat_i = !(host_drv || host_dat_oe);
    assign card_io_i  = ~(card_drv | card_io_oe);

    card_switch i_card_switch (
        .clk(clk), .rst_n(rst_n), .sel(sel), .en(en), .vsel(vsel), .run(run),
        .host_rst(host_rst), .host_clk(host_clk), .host_dat_i(host_dat_i),
        .host_dat_oe(host_dat_oe), .card_io_i(card_io_i), .card_io_oe(card_io_oe),
        .card_rst(card_rst), .card_clk(card_clk), .card_vlvl(card_vlvl)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clk_phase(logic hc, logic [1:0] exp, int n, string req);
        host_clk = hc;
        for (int k = 0; k < n; k++) begin
            step();
            check(req, card_clk, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        // R12 reset state
        check("R12 reset io_oe", card_io_oe, 2'b11);
        check("R12 reset clk", card_clk, 2'b00);
        check("R12 reset rst", card_rst, 2'b00);
        check("R12 reset host_oe", host_dat_oe, 1'b0);
        check("R2 reset vlvl", card_vlvl, 2'b00);
        rst_n = 1'b1;

        // R2 sweep over select and both voltage bits
        for (int v = 0; v < 4; v++) begin
            for (int s = 0; s < 2; s++) begin
                vsel = v[1:0]; sel = s[0];
                step();
                check("R2 vlvl", card_vlvl, v[1:0]);
            end
        end

        // R12 disabled channels stay quiet under any select/run/clock
        for (int k = 0; k < 8; k++) begin
            sel = k[0]; run = 2'b11; host_rst = 1'b1; host_clk = k[1];
            step();
            check("R12 io_oe", card_io_oe, 2'b11);
            check("R12 rst", card_rst, 2'b00);
            check("R12 clk", card_clk, 2'b00);
            check("R6 host_oe", host_dat_oe, 1'b0);
        end

        en = 2'b11; sel = 1'b0; run = 2'b00; host_rst = 1'b0; host_clk = 1'b0;
        step(); step();
        check("R5 released", card_io_oe, 2'b00);

        // R1 R3 R4 R5 per selected channel
        for (int s = 0; s < 2; s++) begin
            sel = s[0];
            step(); step();
            host_drv = 1'b1; step();
            check("R1 R3 host low", card_io_oe, (s == 0) ? 2'b01 : 2'b10);
            check("R4 no echo", host_dat_oe, 1'b0);
            host_drv = 1'b0; step();
            check("R3 host release", card_io_oe, 2'b00);
            card_drv[s] = 1'b1; step();
            check("R4 card low", host_dat_oe, 1'b1);
            check("R4 no echo card", card_io_oe, 2'b00);
            card_drv[s] = 1'b0; step();
            check("R4 card release", host_dat_oe, 1'b0);
            card_drv[1-s] = 1'b1; step(); step();
            check("R5 deselected low", host_dat_oe, 1'b0);
            card_drv = 2'b00; step();
        end

        // R6 no channel enabled, then selected one disabled
        en = 2'b00; card_drv = 2'b11; step(); step();
        check("R6 none enabled", host_dat_oe, 1'b0);
        check("R6 line high", host_dat_i, 1'b1);
        en = 2'b10; sel = 1'b0; step(); step();
        check("R6 selected disabled", host_dat_oe, 1'b0);
        card_drv = 2'b00;

        // R7 R8 reset routing
        en = 2'b11; sel = 1'b0; host_rst = 1'b1; step();
        check("R7 follow A", card_rst, 2'b01);
        sel = 1'b1; host_rst = 1'b0; step();
        check("R8 hold A", card_rst, 2'b01);
        host_rst = 1'b1; step();
        check("R7 follow B", card_rst, 2'b11);
        sel = 1'b0; host_rst = 1'b0; step();
        check("R8 hold B", card_rst, 2'b10);

        // clock paths
        sel = 1'b0; run = 2'b00; host_clk = 1'b0; step(); step();
        clk_phase(1'b1, 2'b01, 2, "R1 clock A");
        sel = 1'b1;
        clk_phase(1'b1, 2'b01, 1, "R11 pulse completes");
        clk_phase(1'b0, 2'b00, 2, "R11 low phase");
        clk_phase(1'b1, 2'b10, 2, "R10 A gated");
        clk_phase(1'b0, 2'b00, 2, "R10 low");
        run = 2'b01;
        clk_phase(1'b0, 2'b00, 1, "R9 low");
        clk_phase(1'b1, 2'b11, 2, "R9 run A");
        clk_phase(1'b0, 2'b00, 2, "R9 low");
        run = 2'b00;
        clk_phase(1'b0, 2'b00, 1, "R10 low");
        for (int p = 0; p < 2; p++) begin
            clk_phase(1'b1, 2'b10, 2, "R10 stays low");
            clk_phase(1'b0, 2'b00, 2, "R10 stays low");
        end
        run = 2'b01;
        clk_phase(1'b0, 2'b00, 1, "R9 low");
        clk_phase(1'b1, 2'b11, 1, "R9 run A");
        en = 2'b10; step();
        check("R12 clk drop", card_clk, 2'b10);
        check("R12 io held", card_io_oe, 2'b01);
        check("R12 rst low", card_rst[0], 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule